// File: doc/BRIEF.md
# Joystick Axis Timer

This block times up to four joystick axes. Each axis has an external comparator that stays high while its RC network charges. Software selects the axes to measure and the counting rate, then writes the value register to start a measurement. From that point each selected axis counts prescaled ticks for as long as its comparator input stays high. When every selected axis has stopped, or when any counter reaches its full-scale value, the counts are copied into holding registers. A ready flag is then raised and, if enabled, an interrupt line.

A two-bit field in the axis-configuration register chooses which held count the value register returns. Reading the value register clears the ready flag. A continuous mode restarts the measurement from a free-running interval counter, so fresh counts keep arriving without software writes. The analog network, the comparators and button handling are outside the block. Comparator results arrive as plain digital inputs.

Register map (two-bit `addr`): 0 is the axis configuration, 1 is the value register, 2 is the rate/interrupt configuration, and 3 reads as zero.

Top module: `joy_axis_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, the ready flag is clear and `irq` is low.
- R2: A write to address 1 (any data) starts a measurement. Each enabled axis counter restarts from zero and adds one on every tick while its `comp_in` bit is high. It stops for good on the first cycle that bit is low, so an axis whose input is already low keeps a count of zero.
- R3: Address 0 bits 3:0 enable axes 0 to 3. An axis whose bit is clear neither counts nor runs, and its held count after the measurement is zero.
- R4: Address 0 bit 7 (read only) is the ready flag. It is set, and the held counts are updated, one cycle after the last enabled axis stops. With no axis enabled, this happens one cycle after the start.
- R5: A counter stops at all-ones (0xFFFF at the default width). Reaching that value ends the whole measurement, even if other axes are still running.
- R6: Address 0 bits 5:4 choose the axis whose held count is read at address 1: 0 for axis 0, 1 for axis 1, 2 for axis 2, 3 for axis 3.
- R7: Address 2 bits 2:1 set the tick rate. 0 gives a tick on every clock, 1 on every 2nd, 2 on every 20th and 3 on every 200th. The tick phase restarts with each measurement start.
- R8: Address 2 bit 0 enables the interrupt. `irq` is high exactly while the ready flag and that bit are both set. Address 2 bits 7:3 always read zero.
- R9: A read strobe at address 1 clears the ready flag on the next edge, unless a measurement completes or starts in that same cycle.
- R10: With address 0 bit 6 set, a measurement start is issued by hardware once every INTERVAL clocks, counted from the cycle the bit was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr` |
| rd_en | input | 1 | Read strobe for `addr` (side effect at address 1 only) |
| addr | input | 2 | Register select |
| wdata | input | 7 | Write data; widest writable field is 7 bits |
| comp_in | input | 4 | Comparator level per axis, high while charging |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | Measurement-ready interrupt |

## Verification
The assertions take for granted that a write and a read strobe never share a cycle. They also assume the slow-rate divisors are at least two, since the tick-spacing check relies on it. The stimulus drives only one strobe per transfer and keeps the default divisors. It changes `comp_in` only between clock edges, and lowers each axis input at a chosen point to set that axis's count. Continuous mode runs with a shortened interval, so several hardware restarts land inside and across running measurements.

// File: rtl/joy_axis_pkg.sv
`timescale 1ns/1ps
package joy_axis_pkg;

    localparam int NUM_AXES = 4;

    typedef enum logic [1:0] {
        REG_AXCFG = 2'd0,
        REG_VALUE = 2'd1,
        REG_HWCFG = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RATE_FULL      = 2'd0,
        RATE_HALF      = 2'd1,
        RATE_TWENTIETH = 2'd2,
        RATE_SLOW      = 2'd3
    } rate_e;

    // axis configuration, 7 writable bits; ready is appended on read
    typedef struct packed {
        logic                cont;
        logic [1:0]          pick;
        logic [NUM_AXES-1:0] en;
    } axcfg_t;

    // rate and interrupt configuration
    typedef struct packed {
        rate_e rate;
        logic  irq_en;
    } hwcfg_t;

endpackage

// File: rtl/joy_tick_gen.sv
`timescale 1ns/1ps
module joy_tick_gen
    import joy_axis_pkg::*;
#(
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOW      = 200
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  rate_e rate,
    output logic  tick
);
    localparam int PW = $clog2(DIV_SLOW);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    always_comb begin
        case (rate)
            RATE_HALF:      lim = PW'(DIV_HALF - 1);
            RATE_TWENTIETH: lim = PW'(DIV_TWENTIETH - 1);
            RATE_SLOW:      lim = PW'(DIV_SLOW - 1);
            default:        lim = '0;
        endcase
    end

    assign tick = (pcnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || rate == RATE_FULL));

endmodule

// File: rtl/joy_interval.sv
`timescale 1ns/1ps
module joy_interval #(
    parameter int INTERVAL = 800000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic fire
);
    localparam int IW = $clog2(INTERVAL);

    logic [IW-1:0] icnt;
    logic          wrap;

    assign wrap = (icnt == IW'(INTERVAL - 1));
    assign fire = enable && wrap;

    always_ff @(posedge clk) begin
        if (rst || !enable) icnt <= '0;
        else if (wrap)      icnt <= '0;
        else                icnt <= icnt + 1'b1;
    end

    // R10
    fire_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/joy_axis_ctr.sv
`timescale 1ns/1ps
module joy_axis_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             en,
    input  logic             comp,
    input  logic             tick,
    input  logic             halt,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] FULL = '1;

    assign at_max = (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= en;
        end else if (halt) begin
            run <= 1'b0;
        end else if (run) begin
            if (!comp || at_max) run <= 1'b0;
            else if (tick)       cnt <= cnt + 1'b1;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt));

    // R5
    sat_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (at_max && !start) |=> !run);

endmodule

// File: rtl/joy_axis_timer.sv
`timescale 1ns/1ps
module joy_axis_timer
    import joy_axis_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOW      = 200,
    parameter int INTERVAL      = 800000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [6:0]       wdata,
    input  logic [3:0]       comp_in,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    axcfg_t   cfg_q;
    hwcfg_t   hw_q;
    logic     ready_q;
    logic     active_q;
    reg_sel_e sel;

    logic wr_val, rd_val, fire, trig, tick, done;
    logic [NUM_AXES-1:0] run;
    logic [NUM_AXES-1:0] at_max;
    logic [CNT_W-1:0]    cnt [NUM_AXES];
    logic [CNT_W-1:0]    lat [NUM_AXES];

    assign sel    = reg_sel_e'(addr);
    assign wr_val = wr_en && (sel == REG_VALUE);
    assign rd_val = rd_en && (sel == REG_VALUE);
    assign trig   = wr_val || fire;
    assign done   = active_q && ((run == '0) || (|at_max));

    joy_tick_gen #(
        .DIV_HALF(DIV_HALF), .DIV_TWENTIETH(DIV_TWENTIETH), .DIV_SLOW(DIV_SLOW)
    ) u_tick (
        .clk(clk), .rst(rst), .restart(trig), .rate(hw_q.rate), .tick(tick)
    );

    joy_interval #(.INTERVAL(INTERVAL)) u_ivl (
        .clk(clk), .rst(rst), .enable(cfg_q.cont), .fire(fire)
    );

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        joy_axis_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst(rst), .start(trig), .en(cfg_q.en[g]),
            .comp(comp_in[g]), .tick(tick), .halt(done),
            .cnt(cnt[g]), .run(run[g]), .at_max(at_max[g])
        );

        always_ff @(posedge clk) begin
            if (rst)                lat[g] <= '0;
            else if (done && !trig) lat[g] <= cnt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            hw_q  <= '0;
        end else if (wr_en && sel == REG_AXCFG) begin
            cfg_q <= axcfg_t'(wdata);
        end else if (wr_en && sel == REG_HWCFG) begin
            hw_q <= hwcfg_t'(wdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ready_q  <= 1'b0;
        end else if (trig) begin
            active_q <= 1'b1;
            ready_q  <= 1'b0;
        end else if (done) begin
            active_q <= 1'b0;
            ready_q  <= 1'b1;
        end else if (rd_val) begin
            ready_q  <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            REG_AXCFG: rdata = CNT_W'({ready_q, cfg_q});
            REG_VALUE: rdata = lat[cfg_q.pick];
            REG_HWCFG: rdata = CNT_W'(hw_q);
            default:   rdata = '0;
        endcase
    end

    assign irq = ready_q && hw_q.irq_en;

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(active_q));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_val && ready_q && !done && !trig) |=> !ready_q);

endmodule

// File: tb/tb_joy_axis_timer.sv
`timescale 1ns/1ps
module tb_joy_axis_timer;
    localparam int IV = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [6:0]  wdata = 7'd0;
    logic [3:0]  comp_in = 4'd0;
    logic [15:0] rdata;
    logic        irq;

    joy_axis_timer #(.INTERVAL(IV)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .comp_in(comp_in), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int    vectors = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_active, m_ready;
    bit m_run [4];
    int m_cnt [4];
    int m_lat [4];
    int m_presc, m_ivl, m_cfg, m_hw;

    function automatic int divisor(int hw);
        case ((hw >> 1) & 3)
            0: return 1;
            1: return 2;
            2: return 20;
            default: return 200;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_ready = 0; m_presc = 0; m_ivl = 0; m_cfg = 0; m_hw = 0;
            for (int i = 0; i < 4; i++) begin m_run[i] = 0; m_cnt[i] = 0; m_lat[i] = 0; end
        end else begin
            bit cont, trig, tick, anyrun, anymax, done, rdv;
            cont = ((m_cfg >> 6) & 1) != 0;
            trig = (wr_en && addr == 2'd1) || (cont && m_ivl == IV - 1);
            tick = m_presc >= divisor(m_hw) - 1;
            anyrun = 0; anymax = 0;
            for (int i = 0; i < 4; i++) begin
                if (m_run[i]) anyrun = 1;
                if (m_cnt[i] == 65535) anymax = 1;
            end
            done = m_active && (!anyrun || anymax);
            rdv = rd_en && addr == 2'd1;
            if (!cont) m_ivl = 0;
            else m_ivl = (m_ivl == IV - 1) ? 0 : m_ivl + 1;
            if (trig) m_presc = 0;
            else m_presc = tick ? 0 : m_presc + 1;
            if (trig) begin
                for (int i = 0; i < 4; i++) begin
                    m_cnt[i] = 0;
                    m_run[i] = ((m_cfg >> i) & 1) != 0;
                end
                m_active = 1; m_ready = 0;
            end else if (done) begin
                m_active = 0; m_ready = 1;
                for (int i = 0; i < 4; i++) begin m_lat[i] = m_cnt[i]; m_run[i] = 0; end
            end else begin
                for (int i = 0; i < 4; i++) begin
                    if (m_run[i]) begin
                        if (!comp_in[i] || m_cnt[i] == 65535) m_run[i] = 0;
                        else if (tick) m_cnt[i]++;
                    end
                end
                if (rdv) m_ready = 0;
            end
            if (wr_en && addr == 2'd0) m_cfg = int'(wdata);
            if (wr_en && addr == 2'd2) m_hw = int'(wdata) & 7;
        end
    end

    function automatic int exp_rdata();
        case (addr)
            2'd0: return (int'(m_ready) << 7) | m_cfg;
            2'd1: return m_lat[(m_cfg >> 4) & 3];
            2'd2: return m_hw;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            check(cur_req, int'(rdata), exp_rdata(), "rdata");
            check(cur_req, int'(irq), int'(m_ready && (m_hw & 1) != 0), "irq");
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1 wr_en = 1'b1; addr = 2'(a); wdata = 7'(d);
        @(posedge clk); #1 wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(int a);
        @(posedge clk); #1 rd_en = 1'b1; addr = 2'(a);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic peek(int a);
        @(posedge clk); #1 addr = 2'(a);
        @(posedge clk); #1;
    endtask

    task automatic drive(logic [3:0] v);
        @(posedge clk); #1 comp_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        idle(3);
        #1 rst = 1'b0;
        chk_on = 1'b1;
        // R1 reset state
        cur_req = "R1";
        #1 check("R1", int'(rdata), 0, "cfg after reset");
        check("R1", int'(irq), 0, "irq after reset");
        peek(2);
        check("R1", int'(rdata), 0, "hwcfg after reset");

        // R8 upper bits of hwcfg read zero
        cur_req = "R8";
        wr(2, 7'h7F);
        peek(2);
        check("R8", int'(rdata), 16'h0007, "hwcfg readback");
        wr(2, 0);

        // R2 R3 R4: axes 0 and 2 enabled, axis 3 enabled but input low
        cur_req = "R2";
        wr(0, 7'b000_1101);
        drive(4'b0111);
        wr(1, 0);
        idle(9);
        drive(4'b0110);
        idle(6);
        drive(4'b0010);
        cur_req = "R4";
        idle(4);
        peek(0);
        check("R4", int'(rdata[7]), 1, "ready after all stopped");
        cur_req = "R6";
        for (int p = 0; p < 4; p++) begin
            wr(0, (p << 4) | 4'b1101);
            peek(1);
        end
        wr(0, 7'b001_1101);
        peek(1);
        check("R3", int'(rdata), 0, "disabled axis 1 count");
        wr(0, 7'b011_1101);
        peek(1);
        check("R2", int'(rdata), 0, "axis 3 with low input");

        // R4 no axis enabled
        cur_req = "R4";
        wr(0, 0);
        wr(1, 0);
        idle(2);
        peek(0);
        check("R4", int'(rdata[7]), 1, "ready with nothing enabled");

        // R7 each rate
        cur_req = "R7";
        for (int r = 0; r < 4; r++) begin
            wr(2, r << 1);
            wr(0, 7'b000_1111);
            drive(4'b1111);
            wr(1, 0);
            idle(97 + r);
            drive(4'b1110);
            idle(233);
            drive(4'b1100);
            idle(411);
            drive(4'b1000);
            idle(3);
            drive(4'b0000);
            idle(3);
            for (int p = 0; p < 4; p++) begin
                wr(0, (p << 4) | 4'hF);
                peek(1);
            end
        end

        // R8 R9 interrupt and read-clear
        cur_req = "R8";
        wr(2, 7'b000_0001);
        wr(0, 7'b000_0001);
        drive(4'b0001);
        wr(1, 0);
        idle(12);
        drive(4'b0000);
        idle(3);
        check("R8", int'(irq), 1, "irq while ready");
        cur_req = "R9";
        rd(1);
        #1 check("R9", int'(irq), 0, "irq after value read");
        peek(0);
        check("R9", int'(rdata[7]), 0, "ready after value read");
        rd(0);
        wr(1, 0);
        idle(3);
        rd(2);
        peek(0);
        check("R9", int'(rdata[7]), 1, "other reads keep ready");

        // R10 continuous mode
        cur_req = "R10";
        wr(2, 7'b000_0011);
        wr(0, 7'b100_0011);
        for (int k = 0; k < 5; k++) begin
            drive(4'b0011);
            idle(150 + 7 * k);
            drive(4'b0001);
            idle(90);
            drive(4'b0000);
            idle(120);
            rd(1);
        end
        wr(0, 0);
        idle(5);

        // R5 saturation ends the measurement early
        cur_req = "R5";
        wr(2, 0);
        wr(0, 7'b000_0011);
        drive(4'b0011);
        wr(1, 0);
        idle(65545);
        peek(1);
        check("R5", int'(rdata), 16'hFFFF, "saturated count");
        peek(0);
        check("R5", int'(rdata[7]), 1, "ready after saturation");
        drive(4'b0000);
        idle(2);

        finish_run();
    end
endmodule